// File: doc/BRIEF.md
# Masked Interrupt Aggregation Controller

This block gathers up to 32 interrupt sources into one source vector. The sources are peripheral event pulses and external interrupt lines. Each pulse sets a sticky status bit. A mask register decides which of those bits may reach the processor. The single registered interrupt request is high whenever an enabled source is pending.

Software reaches three word registers over a plain register bus with address, write enable, write data and read data.

- **Status** shows every latched source, whatever the mask holds. A peripheral can therefore be polled with interrupts disabled. Writing ones to status clears the matching bits.
- **Cause** is a live view: status ANDed with mask. Writing ones to cause sets the matching status bits, so software can raise any interrupt for test.
- **Mask** is a plain read/write enable register.

Source bit map (wiring only, no logic depends on it):

| Bits | Source |
|------|--------|
| 9..0 | External lines 0 to 9 |
| 31 | Single-bit memory error |
| 30 | Multi-bit memory error |
| 23 | Read access violation |
| 22 | Write access violation |
| 21..16 | Serial channel 1 flags: receive-ready, transmit-ready, transmit-empty, receive-overrun, framing-error, spare |
| 15..10 | Serial channel 0 flags: receive-ready, transmit-ready, transmit-empty, receive-overrun, framing-error, spare |

Top module: `irq_agg`

## Requirements
- R1: While reset is asserted, and right after it, status and mask read zero and `irq_o` is low. Reset acts asynchronously and is released through a two-flop synchronizer.
- R2: A one-cycle pulse on `src_pulse[i]` sets status bit i at the next clock edge. The bit stays set until software clears it.
- R3: Status reports every latched source whatever the mask holds, including sources whose mask bit is zero.
- R4: A bus write to address 0 (status) clears each status bit whose write-data bit is 1. Bits written 0 are unchanged.
- R5: A read of address 1 (cause) returns status AND mask in the same cycle.
- R6: A bus write to address 1 (cause) sets each status bit whose write-data bit is 1 (software-raised interrupt).
- R7: A bus write to address 2 (mask) loads the mask, which reads back at address 2. A mask write leaves status unchanged, and the mask changes on no other access.
- R8: When a set (source pulse) and a clear (status write) hit the same bit in the same cycle, the bit ends set.
- R9: `irq_o` is the OR of all cause bits, registered: it rises or falls one clock edge after the cause value becomes nonzero or zero.
- R10: Address 3 reads zero, and writes to it change neither status nor mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| src_pulse | input | 32 | Source event pulses, one bit per source |
| bus_addr | input | 2 | Register word index: 0 status, 1 cause, 2 mask, 3 unused |
| bus_we | input | 1 | Write strobe for one cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| irq_o | output | 1 | Registered interrupt request to the processor |

## Verification
Source pulses are applied to both masked and unmasked bits, so a cause read tells the live AND of status and mask apart from a raw copy of status. Status writes use partial bit patterns, which separate the write-one-to-clear rule from a whole-register clear. A cause write of the two top bits tells the software set path apart from the mask path. A clear that lands in the same cycle as a source pulse exposes any bias toward the clear.

Writes to the unused address show whether the address decode leaks into the mask or status registers. Separate directed tests cover the following:
- the one-cycle lag of `irq_o` as it rises;
- the same lag as it falls;
- an asynchronous reset applied in the middle of a run.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned ADDR_W = 2;

  typedef enum logic [ADDR_W-1:0] {
    REG_STATUS = 2'd0,
    REG_CAUSE  = 2'd1,
    REG_MASK   = 2'd2,
    REG_SPARE  = 2'd3
  } reg_sel_e;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/irq_status_bank.sv
module irq_status_bank #(
  parameter int unsigned NSRC = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [NSRC-1:0] set_vec,
  input  logic [NSRC-1:0] clr_vec,
  output logic [NSRC-1:0] status_q
);
  logic [NSRC-1:0] status_d;

  for (genvar i = 0; i < NSRC; i++) begin : g_bit
    // set dominates a simultaneous clear
    always_comb begin
      status_d[i] = set_vec[i] | (status_q[i] & ~clr_vec[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) status_q[i] <= 1'b0;
      else        status_q[i] <= status_d[i];
    end
  end
endmodule

// File: rtl/irq_bus_regs.sv
module irq_bus_regs
  import irq_agg_pkg::*;
#(
  parameter int unsigned NSRC = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [NSRC-1:0]   bus_wdata,
  input  logic [NSRC-1:0]   status_q,
  output logic [NSRC-1:0]   mask_q,
  output logic [NSRC-1:0]   sw_set,
  output logic [NSRC-1:0]   sw_clr,
  output logic [NSRC-1:0]   bus_rdata
);
  reg_sel_e        sel;
  logic            mask_en;
  logic [NSRC-1:0] mask_d;

  always_comb begin
    sel     = reg_sel_e'(bus_addr);
    mask_en = bus_we && (sel == REG_MASK);
    mask_d  = bus_wdata;
    sw_set  = (bus_we && sel == REG_CAUSE)  ? bus_wdata : '0;
    sw_clr  = (bus_we && sel == REG_STATUS) ? bus_wdata : '0;
    unique case (sel)
      REG_STATUS: bus_rdata = status_q;
      REG_CAUSE:  bus_rdata = status_q & mask_q;
      REG_MASK:   bus_rdata = mask_q;
      default:    bus_rdata = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       mask_q <= '0;
    else if (mask_en) mask_q <= mask_d;
  end
endmodule

// File: rtl/irq_agg.sv
module irq_agg
  import irq_agg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [WORD_W-1:0] src_pulse,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [WORD_W-1:0] bus_wdata,
  output logic [WORD_W-1:0] bus_rdata,
  output logic              irq_o
);
  logic              rst_sync_n;
  logic [WORD_W-1:0] status_q;
  logic [WORD_W-1:0] mask_q;
  logic [WORD_W-1:0] sw_set;
  logic [WORD_W-1:0] sw_clr;
  logic [WORD_W-1:0] set_vec;
  logic              irq_d;
  logic              irq_q;

  irq_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  irq_bus_regs #(.NSRC(WORD_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .status_q  (status_q),
    .mask_q    (mask_q),
    .sw_set    (sw_set),
    .sw_clr    (sw_clr),
    .bus_rdata (bus_rdata)
  );

  always_comb begin
    set_vec = src_pulse | sw_set;
    irq_d   = |(status_q & mask_q);
  end

  irq_status_bank #(.NSRC(WORD_W)) u_bank (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_vec  (set_vec),
    .clr_vec  (sw_clr),
    .status_q (status_q)
  );

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) irq_q <= 1'b0;
    else             irq_q <= irq_d;
  end

  assign irq_o = irq_q;
endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk (
  input logic        clk,
  input logic        rst_sync_n,
  input logic [31:0] src_pulse,
  input logic [1:0]  bus_addr,
  input logic        bus_we,
  input logic [31:0] bus_wdata,
  input logic [31:0] status_q,
  input logic [31:0] mask_q,
  input logic        irq_o
);
  assert_src_sets_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> ((status_q & $past(src_pulse)) == $past(src_pulse)));

  assert_sticky_R2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we && bus_addr == 2'd0) |=> ((status_q & $past(status_q)) == $past(status_q)));

  assert_w1c_R4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == 2'd0) |=>
      ((status_q & $past(bus_wdata) & ~$past(src_pulse)) == 32'd0));

  assert_sw_set_R6: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (bus_we && bus_addr == 2'd1) |=> ((status_q & $past(bus_wdata)) == $past(bus_wdata)));

  assert_mask_hold_R7: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !(bus_we && bus_addr == 2'd2) |=> $stable(mask_q));

  assert_irq_lag_R9: assert property (@(posedge clk) disable iff (!rst_sync_n)
    1'b1 |=> (irq_o == ($past(status_q & mask_q) != 32'd0)));
endmodule

bind irq_agg irq_agg_chk u_chk (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .src_pulse  (src_pulse),
  .bus_addr   (bus_addr),
  .bus_we     (bus_we),
  .bus_wdata  (bus_wdata),
  .status_q   (status_q),
  .mask_q     (mask_q),
  .irq_o      (irq_o)
);

// File: tb/irq_agg_tb.sv
module irq_agg_tb;
  typedef struct packed {
    logic [1:0]  waddr;
    logic        we;
    logic [31:0] wdata;
    logic [31:0] src;
    logic [1:0]  raddr;
    logic [31:0] exp;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t TBL [NV] = '{
    '{2'd0, 1'b0, 32'h0,          32'h0000_0205, 2'd0, 32'h0000_0205, 4'd2},  // R2 set
    '{2'd0, 1'b0, 32'h0,          32'h0,         2'd0, 32'h0000_0205, 4'd2},  // R2 sticky
    '{2'd2, 1'b1, 32'h0000_0005,  32'h0,         2'd2, 32'h0000_0005, 4'd7},  // R7 readback
    '{2'd0, 1'b0, 32'h0,          32'h0,         2'd1, 32'h0000_0005, 4'd5},  // R5 cause
    '{2'd0, 1'b1, 32'h0000_0004,  32'h0,         2'd0, 32'h0000_0201, 4'd4},  // R4 partial clear
    '{2'd1, 1'b1, 32'hC000_0000,  32'h0,         2'd0, 32'hC000_0201, 4'd6},  // R6 sw set
    '{2'd0, 1'b0, 32'h0,          32'h0,         2'd1, 32'h0000_0001, 4'd5},  // R5 masked out
    '{2'd0, 1'b0, 32'h0,          32'h00C0_0000, 2'd0, 32'hC0C0_0201, 4'd3},  // R3 unmasked visible
    '{2'd3, 1'b1, 32'hFFFF_FFFF,  32'h0,         2'd3, 32'h0,         4'd10}, // R10 reads zero
    '{2'd0, 1'b0, 32'h0,          32'h0,         2'd2, 32'h0000_0005, 4'd10}, // R10 mask untouched
    '{2'd0, 1'b1, 32'hFFFF_FFFF,  32'h0000_0008, 2'd0, 32'h0000_0008, 4'd8},  // R8 set wins
    '{2'd2, 1'b1, 32'h0,          32'h0,         2'd0, 32'h0000_0008, 4'd7}   // R7 status kept
  };

  logic        clk;
  logic        rst_n;
  logic [31:0] src_pulse;
  logic [1:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic [31:0] bus_rdata;
  logic        irq_o;
  int          checks;
  int          errors;
  bit          done;

  irq_agg u_dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .src_pulse (src_pulse),
    .bus_addr  (bus_addr),
    .bus_we    (bus_we),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .irq_o     (irq_o)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_we = 1'b0; bus_wdata = '0; src_pulse = '0;
  endtask

  initial begin
    checks = 0; errors = 0; done = 1'b0;
    rst_n = 1'b0; bus_addr = 2'd0; idle();
    repeat (3) @(posedge clk);
    @(negedge clk);
    #1 check("R1 status in reset", bus_rdata, 32'h0);
    bus_addr = 2'd2;
    #1 check("R1 mask in reset", bus_rdata, 32'h0);
    check("R1 irq in reset", {31'd0, irq_o}, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    #1 check("R1 mask after release", bus_rdata, 32'h0);
    check("R1 irq after release", {31'd0, irq_o}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      bus_addr = TBL[k].waddr; bus_we = TBL[k].we;
      bus_wdata = TBL[k].wdata; src_pulse = TBL[k].src;
      @(posedge clk);
      @(negedge clk);
      idle(); bus_addr = TBL[k].raddr;
      #1 check($sformatf("R%0d vector %0d", TBL[k].req, k), bus_rdata, TBL[k].exp);
    end

    // R9: status holds 0x8, mask 0; enable bit 3
    bus_addr = 2'd2; bus_we = 1'b1; bus_wdata = 32'h8;
    @(posedge clk); @(negedge clk); idle();
    #1 check("R9 irq lags rise", {31'd0, irq_o}, 32'h0);
    @(negedge clk);
    #1 check("R9 irq high", {31'd0, irq_o}, 32'h1);
    bus_addr = 2'd0; bus_we = 1'b1; bus_wdata = 32'h8;
    @(posedge clk); @(negedge clk); idle();
    #1 check("R9 irq lags fall", {31'd0, irq_o}, 32'h1);
    @(negedge clk);
    #1 check("R9 irq low", {31'd0, irq_o}, 32'h0);

    // R1 async reset mid-run
    bus_addr = 2'd1; bus_we = 1'b1; bus_wdata = 32'h8;
    @(posedge clk); @(negedge clk); idle(); bus_addr = 2'd2;
    @(negedge clk);
    #1 check("R9 irq from sw set", {31'd0, irq_o}, 32'h1);
    rst_n = 1'b0;
    #1 check("R1 mid-run mask", bus_rdata, 32'h0);
    check("R1 mid-run irq", {31'd0, irq_o}, 32'h0);
    bus_addr = 2'd0;
    #1 check("R1 mid-run status", bus_rdata, 32'h0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual timeout expected completion");
      end
    join_any
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule